// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control unit of a multicycle processor datapath. It keeps a small state register that steps each instruction through a series of one-cycle phases. Every phase uses one major datapath resource. In each phase the block presents a fixed set of enables and multiplexer selects to the datapath. The first two phases are the same for every instruction: instruction fetch, then decode together with register read. After decode the block branches on the opcode to one of four instruction flavours. It branches again after address computation, to separate the load path from the store path.

The outputs depend only on the current state, so the block is a Moore machine. The opcode is used only to choose the next state. The datapath must hold the opcode stable from the end of fetch until the instruction finishes. The block accepts five instruction kinds: register-to-register arithmetic, load word, store word, branch-if-equal and jump. Any other opcode seen at decode drops the machine back to fetch without touching processor state.

Top module: `mcf_ctrl_fsm`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the machine enters fetch. After reset is released, the outputs show the fetch vector until the next edge.
- R2: Fetch drives pc_wr_en=1, mem_rd=1, ir_load=1, mem_addr_sel=0, alu_a_sel=0, alu_b_sel=01, alu_mode=00 and pc_next_sel=00. Decode always follows fetch, whatever the opcode.
- R3: Decode drives alu_a_sel=0, alu_b_sel=11 and alu_mode=00. The next state depends on the opcode: 100011 (load) or 101011 (store) go to address computation, 000000 goes to arithmetic execute, 000100 goes to branch and 000010 goes to jump.
- R4: At decode, any opcode other than the five listed in R3 returns the machine to fetch.
- R5: Address computation drives alu_a_sel=1, alu_b_sel=10 and alu_mode=00. The next state is load read for opcode 100011, store write for 101011, and fetch for any other opcode.
- R6: Load read drives mem_rd=1 and mem_addr_sel=1, then moves to load writeback. Load writeback drives rf_wr=1, rf_dst_sel=0 and wb_from_mem=1, then returns to fetch.
- R7: Store write drives mem_wr=1 and mem_addr_sel=1, then returns to fetch.
- R8: Arithmetic execute drives alu_a_sel=1, alu_b_sel=00 and alu_mode=10, then moves to arithmetic completion. Arithmetic completion drives rf_wr=1, rf_dst_sel=1 and wb_from_mem=0, then returns to fetch.
- R9: Branch drives alu_a_sel=1, alu_b_sel=00, alu_mode=01, pc_wr_cond=1 and pc_next_sel=01, then returns to fetch.
- R10: Jump drives pc_wr_en=1 and pc_next_sel=10, then returns to fetch.
- R11: Every output not named for a state is 0 in that state. A change of `opcode` within a cycle never changes any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| opcode | input | 6 | Primary opcode field of the held instruction |
| pc_wr_en | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write qualified by the ALU zero flag |
| mem_addr_sel | output | 1 | Memory address select: 0 program counter, 1 ALU result register |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| wb_from_mem | output | 1 | Register write data select: 1 memory data register, 0 ALU result |
| ir_load | output | 1 | Instruction register load enable |
| pc_next_sel | output | 2 | Next program counter source: 00 ALU, 01 ALU result register, 10 jump target |
| alu_mode | output | 2 | ALU operation: 00 add, 01 subtract, 10 use function field |
| alu_a_sel | output | 1 | First ALU operand: 0 program counter, 1 register A |
| alu_b_sel | output | 2 | Second ALU operand: 00 register B, 01 constant four, 10 extended immediate, 11 shifted immediate |
| rf_wr | output | 1 | Register file write enable |
| rf_dst_sel | output | 1 | Destination register field: 0 rt, 1 rd |

## Verification
The bench builds the block with its default 6-bit opcode width, so the whole opcode space of 64 values can be swept. Each opcode is held through a complete instruction after a reset, which drives every dispatch decision at decode and at address computation, including all unsupported codes. A second phase changes the opcode every cycle in a fixed scrambled pattern and pulses reset now and then. That phase reaches address computation with opcodes other than load and store, and it checks that an opcode change in the middle of a cycle leaves the outputs unchanged.

// File: rtl/mcf_pkg.sv
// Package mcf_pkg
// Shared state encoding, control vector layout and opcode constants for the
// multicycle control sequencer. Assumes a 6-bit primary opcode field.
package mcf_pkg;

    localparam int OPC_W   = 6;
    localparam int STATE_W = 4;

    localparam logic [OPC_W-1:0] OPC_ARITH  = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_JUMP   = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'b101011;

    typedef enum logic [STATE_W-1:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_ADDR    = 4'd2,
        ST_LD_RD   = 4'd3,
        ST_LD_WB   = 4'd4,
        ST_ST_WR   = 4'd5,
        ST_AR_EXE  = 4'd6,
        ST_AR_DONE = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9
    } state_e;

    typedef enum logic [2:0] {
        CL_ARITH, CL_LOAD, CL_STORE, CL_BRANCH, CL_JUMP, CL_OTHER
    } op_class_e;

    typedef struct packed {
        logic       pc_wr_en;
        logic       pc_wr_cond;
        logic       mem_addr_sel;
        logic       mem_rd;
        logic       mem_wr;
        logic       wb_from_mem;
        logic       ir_load;
        logic [1:0] pc_next_sel;
        logic [1:0] alu_mode;
        logic       alu_a_sel;
        logic [1:0] alu_b_sel;
        logic       rf_wr;
        logic       rf_dst_sel;
    } ctrl_t;

endpackage

// File: rtl/mcf_op_class.sv
// Module mcf_op_class
// Sorts the primary opcode into one of the supported instruction kinds.
// Every code that matches none of the configured values maps to CL_OTHER.
module mcf_op_class
    import mcf_pkg::*;
#(
    parameter int               OW       = OPC_W,
    parameter logic [OW-1:0]    C_ARITH  = OPC_ARITH,
    parameter logic [OW-1:0]    C_JUMP   = OPC_JUMP,
    parameter logic [OW-1:0]    C_BRANCH = OPC_BRANCH,
    parameter logic [OW-1:0]    C_LOAD   = OPC_LOAD,
    parameter logic [OW-1:0]    C_STORE  = OPC_STORE
) (
    input  logic [OW-1:0] opcode,
    output op_class_e     op_class
);

    // Compare the opcode against each supported code.
    always_comb begin
        if (opcode == C_ARITH)       op_class = CL_ARITH;
        else if (opcode == C_LOAD)   op_class = CL_LOAD;
        else if (opcode == C_STORE)  op_class = CL_STORE;
        else if (opcode == C_BRANCH) op_class = CL_BRANCH;
        else if (opcode == C_JUMP)   op_class = CL_JUMP;
        else                         op_class = CL_OTHER;
    end

endmodule

// File: rtl/mcf_next_state.sv
// Module mcf_next_state
// Next-state function. Fetch and the single-path states advance unconditionally.
// Decode and address computation branch on the opcode class. An unexpected
// class at either branch point returns to fetch.
module mcf_next_state
    import mcf_pkg::*;
(
    input  state_e    state,
    input  op_class_e op_class,
    output state_e    state_nx
);

    // Choose the successor of the current state.
    always_comb begin
        unique case (state)
            ST_FETCH:   state_nx = ST_DECODE;
            ST_DECODE: begin
                unique case (op_class)
                    CL_LOAD,
                    CL_STORE:  state_nx = ST_ADDR;
                    CL_ARITH:  state_nx = ST_AR_EXE;
                    CL_BRANCH: state_nx = ST_BRANCH;
                    CL_JUMP:   state_nx = ST_JUMP;
                    default:   state_nx = ST_FETCH;
                endcase
            end
            ST_ADDR: begin
                if (op_class == CL_LOAD)       state_nx = ST_LD_RD;
                else if (op_class == CL_STORE) state_nx = ST_ST_WR;
                else                           state_nx = ST_FETCH;
            end
            ST_LD_RD:   state_nx = ST_LD_WB;
            ST_AR_EXE:  state_nx = ST_AR_DONE;
            default:    state_nx = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcf_ctrl_decode.sv
// Module mcf_ctrl_decode
// Moore output decoder: maps the current state to its fixed control vector.
// Every field not set for a state stays 0.
module mcf_ctrl_decode
    import mcf_pkg::*;
(
    input  state_e state,
    output ctrl_t  ctrl
);

    // Build the control vector for the current state.
    always_comb begin
        ctrl = '0;
        unique case (state)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_load   = 1'b1;
                ctrl.alu_b_sel = 2'b01;
                ctrl.pc_wr_en  = 1'b1;
            end
            ST_DECODE: begin
                ctrl.alu_b_sel = 2'b11;
            end
            ST_ADDR: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_b_sel = 2'b10;
            end
            ST_LD_RD: begin
                ctrl.mem_rd       = 1'b1;
                ctrl.mem_addr_sel = 1'b1;
            end
            ST_LD_WB: begin
                ctrl.rf_wr       = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            ST_ST_WR: begin
                ctrl.mem_wr       = 1'b1;
                ctrl.mem_addr_sel = 1'b1;
            end
            ST_AR_EXE: begin
                ctrl.alu_a_sel = 1'b1;
                ctrl.alu_mode  = 2'b10;
            end
            ST_AR_DONE: begin
                ctrl.rf_wr      = 1'b1;
                ctrl.rf_dst_sel = 1'b1;
            end
            ST_BRANCH: begin
                ctrl.alu_a_sel   = 1'b1;
                ctrl.alu_mode    = 2'b01;
                ctrl.pc_wr_cond  = 1'b1;
                ctrl.pc_next_sel = 2'b01;
            end
            ST_JUMP: begin
                ctrl.pc_wr_en    = 1'b1;
                ctrl.pc_next_sel = 2'b10;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/mcf_ctrl_fsm.sv
// Module mcf_ctrl_fsm
// Top of the multicycle control sequencer. It holds the state register, which
// is forced to fetch by a synchronous active-low reset. The outputs depend only
// on the state. The datapath must hold the opcode stable from the end of fetch
// until the instruction completes.
module mcf_ctrl_fsm
    import mcf_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [OW-1:0] opcode,
    output logic          pc_wr_en,
    output logic          pc_wr_cond,
    output logic          mem_addr_sel,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          wb_from_mem,
    output logic          ir_load,
    output logic [1:0]    pc_next_sel,
    output logic [1:0]    alu_mode,
    output logic          alu_a_sel,
    output logic [1:0]    alu_b_sel,
    output logic          rf_wr,
    output logic          rf_dst_sel
);

    state_e    state_q;
    state_e    state_nx;
    op_class_e op_class;
    ctrl_t     ctrl;

    mcf_op_class #(.OW(OW)) u_class (
        .opcode   (opcode),
        .op_class (op_class)
    );

    mcf_next_state u_next (
        .state    (state_q),
        .op_class (op_class),
        .state_nx (state_nx)
    );

    mcf_ctrl_decode u_dec (
        .state (state_q),
        .ctrl  (ctrl)
    );

    // State register with synchronous active-low reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_nx;
    end

    // Drive the output pins from the decoded control vector.
    always_comb begin
        pc_wr_en     = ctrl.pc_wr_en;
        pc_wr_cond   = ctrl.pc_wr_cond;
        mem_addr_sel = ctrl.mem_addr_sel;
        mem_rd       = ctrl.mem_rd;
        mem_wr       = ctrl.mem_wr;
        wb_from_mem  = ctrl.wb_from_mem;
        ir_load      = ctrl.ir_load;
        pc_next_sel  = ctrl.pc_next_sel;
        alu_mode     = ctrl.alu_mode;
        alu_a_sel    = ctrl.alu_a_sel;
        alu_b_sel    = ctrl.alu_b_sel;
        rf_wr        = ctrl.rf_wr;
        rf_dst_sel   = ctrl.rf_dst_sel;
    end

endmodule

// File: rtl/mcf_ctrl_fsm_chk.sv
// Module mcf_ctrl_fsm_chk
// Property checker bound to mcf_ctrl_fsm. It observes the ports and the state
// register and checks the sequencing and the output relations.
module mcf_ctrl_fsm_chk
    import mcf_pkg::*;
#(
    parameter int OW = OPC_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [OW-1:0] opcode,
    input state_e        state_q,
    input logic          pc_wr_en,
    input logic          pc_wr_cond,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [1:0]    pc_next_sel,
    input logic          rf_wr
);

    logic op_known;
    assign op_known = (opcode == OPC_ARITH) || (opcode == OPC_JUMP) ||
                      (opcode == OPC_BRANCH) || (opcode == OPC_LOAD) ||
                      (opcode == OPC_STORE);

    p_fetch_then_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FETCH) |=> (state_q == ST_DECODE));

    p_load_dispatch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && opcode == OPC_LOAD) |=> (state_q == ST_ADDR));

    p_unknown_op_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && !op_known) |=> (state_q == ST_FETCH));

    p_store_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && opcode == OPC_STORE) |=> mem_wr);

    p_load_wb_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !pc_wr_en) |=> rf_wr);

    p_cond_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_wr_cond |-> (pc_next_sel == 2'b01 && !pc_wr_en));

    p_mem_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_wr_returns_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || rf_wr) |=> (state_q == ST_FETCH));

endmodule

bind mcf_ctrl_fsm mcf_ctrl_fsm_chk #(.OW(OW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .opcode      (opcode),
    .state_q     (state_q),
    .pc_wr_en    (pc_wr_en),
    .pc_wr_cond  (pc_wr_cond),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .pc_next_sel (pc_next_sel),
    .rf_wr       (rf_wr)
);

// File: tb/mcf_ctrl_fsm_test.sv
// Bench for mcf_ctrl_fsm. It keeps its own state model written from the
// requirements and compares all outputs with it every cycle.
module mcf_ctrl_fsm_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic       pc_wr_en, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr;
    logic       wb_from_mem, ir_load, alu_a_sel, rf_wr, rf_dst_sel;
    logic [1:0] pc_next_sel, alu_mode, alu_b_sel;

    int checks = 0;
    int errors = 0;
    int mstate = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    mcf_ctrl_fsm uut (
        .clk(clk), .rst_n(rst_n), .opcode(opcode),
        .pc_wr_en(pc_wr_en), .pc_wr_cond(pc_wr_cond), .mem_addr_sel(mem_addr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .wb_from_mem(wb_from_mem),
        .ir_load(ir_load), .pc_next_sel(pc_next_sel), .alu_mode(alu_mode),
        .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel), .rf_wr(rf_wr),
        .rf_dst_sel(rf_dst_sel)
    );

    // Field order: pc_wr_en pc_wr_cond mem_addr_sel mem_rd mem_wr wb_from_mem
    // ir_load pc_next_sel[2] alu_mode[2] alu_a_sel alu_b_sel[2] rf_wr rf_dst_sel
    function automatic logic [15:0] pack(input logic pw, pc, ma, mr, mw, wm, il,
                                         input logic [1:0] ps, am, input logic aa,
                                         input logic [1:0] ab, input logic rw, rd);
        return {pw, pc, ma, mr, mw, wm, il, ps, am, aa, ab, rw, rd};
    endfunction

    function automatic logic [15:0] expect_vec(input int s);
        case (s)
            0: return pack(1,0,0,1,0,0,1, 2'b00, 2'b00, 0, 2'b01, 0,0); // R2
            1: return pack(0,0,0,0,0,0,0, 2'b00, 2'b00, 0, 2'b11, 0,0); // R3
            2: return pack(0,0,0,0,0,0,0, 2'b00, 2'b00, 1, 2'b10, 0,0); // R5
            3: return pack(0,0,1,1,0,0,0, 2'b00, 2'b00, 0, 2'b00, 0,0); // R6
            4: return pack(0,0,0,0,0,1,0, 2'b00, 2'b00, 0, 2'b00, 1,0); // R6
            5: return pack(0,0,1,0,1,0,0, 2'b00, 2'b00, 0, 2'b00, 0,0); // R7
            6: return pack(0,0,0,0,0,0,0, 2'b00, 2'b10, 1, 2'b00, 0,0); // R8
            7: return pack(0,0,0,0,0,0,0, 2'b00, 2'b00, 0, 2'b00, 1,1); // R8
            8: return pack(0,1,0,0,0,0,0, 2'b01, 2'b01, 1, 2'b00, 0,0); // R9
            default: return pack(1,0,0,0,0,0,0, 2'b10, 2'b00, 0, 2'b00, 0,0); // R10
        endcase
    endfunction

    function automatic string req_of(input int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R5";
            3, 4: return "R6";
            5: return "R7";
            6, 7: return "R8";
            8: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int model_next(input int s, input logic [5:0] op);
        case (s)
            0: return 1;
            1: begin
                if (op == 6'b100011 || op == 6'b101011) return 2;
                if (op == 6'b000000) return 6;
                if (op == 6'b000100) return 8;
                if (op == 6'b000010) return 9;
                return 0; // R4
            end
            2: begin
                if (op == 6'b100011) return 3;
                if (op == 6'b101011) return 5;
                return 0;
            end
            3: return 4;
            6: return 7;
            default: return 0;
        endcase
    endfunction

    function automatic logic [15:0] actual_vec();
        return {pc_wr_en, pc_wr_cond, mem_addr_sel, mem_rd, mem_wr, wb_from_mem,
                ir_load, pc_next_sel, alu_mode, alu_a_sel, alu_b_sel, rf_wr, rf_dst_sel};
    endfunction

    task automatic check_outputs(input string req);
        logic [15:0] act;
        logic [15:0] exp;
        act = actual_vec();
        exp = expect_vec(mstate);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s state %0d: outputs %b, expected %b", req, mstate, act, exp);
        end
    endtask

    // One clock step: apply opcode and reset mid-cycle, check that the outputs
    // do not follow the opcode (R11), then advance the model and recheck.
    task automatic step(input logic [5:0] op, input bit rst);
        int nx;
        opcode = op;
        rst_n  = !rst;
        #1;
        check_outputs("R11");
        nx = rst ? 0 : model_next(mstate, op);
        @(negedge clk);
        mstate = nx;
        if (rst) check_outputs("R1");
        else if (mstate == 0 && op != 6'b000000 && op != 6'b000010 &&
                 op != 6'b000100 && op != 6'b100011 && op != 6'b101011)
            check_outputs("R4");
        else check_outputs(req_of(mstate));
    endtask

    initial begin
        rst_n = 1'b0;
        opcode = 6'd0;
        repeat (2) @(negedge clk);
        mstate = 0;
        check_outputs("R1");
        // Sweep every opcode through a whole instruction after a reset.
        for (int op = 0; op < 64; op++) begin
            step(6'(op), 1'b1);
            for (int c = 0; c < 6; c++) step(6'(op), 1'b0);
        end
        // Scrambled opcode stream with occasional resets.
        for (int c = 0; c < 2000; c++) begin
            logic [5:0] op;
            case (c % 5)
                0: op = 6'((c * 37 + 11) % 64);
                1: op = 6'b100011;
                2: op = 6'b101011;
                3: op = (c % 3 == 0) ? 6'b000000 : 6'b000100;
                default: op = 6'b000010;
            endcase
            if ((c * 13) % 7 == 3) op = 6'((c * 29) % 64);
            step(op, (c % 97) == 50);
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule